// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Unit

This block is the register side of a real-time clock: a byte-wide index port selects one of 64 byte registers and a byte-wide data port reads or writes it. Four of those registers drive a periodic interrupt. Control register A (index 0x0A) selects the rate. Register B (index 0x0B) holds the interrupt enable mask. Flag register C (index 0x0C) latches the periodic event and clears when read. Register D (index 0x0D) is read-only and reports valid storage. All other indexes are plain byte storage. Calendar registers keep whatever was last written to them.

A free-running counter advances on each strobe of the `tick` input, which is nominally 1,048,576 Hz. The periodic event fires when that counter reaches a whole multiple of the selected period. It does not count a full period from the moment of arming. After the event fires, the timer stays idle until software reads register C, and the next event again lands on the counter's period grid. Software attaches an interrupt line to `irq` and services it by reading register C.

Top module: `rtc_periodic_unit`

## Requirements
- R1: After reset, A reads 0x26, B reads 0x02, C reads 0x00 and D reads 0x80. `irq` and `wr_err` are 0. The periodic timer is disarmed, so no event occurs until it is armed.
- R2: A write with `bus_sel`=0 loads the index, and a read with `bus_sel`=0 returns the last index written. Every read returns its byte on `bus_rdata`, with `bus_rvalid` high, one cycle after `bus_rd`.
- R3: Indexes 0x00–0x3F, except 0x0A–0x0D, store a written byte and return it on a later read.
- R4: A write to A stores bits 6:0 and reads back bit 7 as 0. A write to B stores the byte with bit 1 forced to 1.
- R5: The following data writes change no register and set `wr_err`: a write to C, a write to D, or a write to an index of 0x40 or above. `wr_err` stays set until reset. A read at an index of 0x40 or above returns 0x00.
- R6: The period is 2^d ticks. A = 0x21 gives d = 12, A = 0x22 gives d = 13, and any other value gives d = 4 + A[3:0]. The rate is invalid when A[6:4] > 2 or A[3:0] = 0, and an invalid rate never arms the timer.
- R7: A write to A, or a read of C, re-evaluates the timer at once. The timer arms only if the rate is valid and C bit 6 is clear after that cycle. Once armed, the event fires on the first later tick whose incremented base count is a multiple of 2^d. The base count starts at 0 at reset.
- R8: The event sets C bit 6 and disarms the timer. While bit 6 is set, no write to A rearms the timer.
- R9: `irq` is a register that equals OR(C[6:4] AND B[6:4]). It changes on the same clock edge as the registers it depends on.
- R10: A read of C returns {request condition, C[6:0]}, where the request condition goes in bit 7. The read then clears C and re-evaluates the timer. If an event coincides with the read, the flag is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base timebase strobe, one cycle per tick |
| bus_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Interrupt request |
| wr_err | output | 1 | Sticky rejected-write flag |

## Verification
The assertions assume that no cycle carries both `bus_wr` and `bus_rd`, and that the counter is at least wide enough for the largest exponent (19), which holds at the default width of 20. The stimulus issues one bus access per cycle through tasks that keep each strobe high for exactly one cycle. It holds `tick` high on every cycle after reset, so the bench's own tick count mirrors the base counter. Before each timer-arming step it first disarms the timer, by writing an invalid rate and reading C, so that no leftover event can fire during the setup.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] IDX_RATE  = 8'h0A;
  localparam logic [7:0] IDX_MASK  = 8'h0B;
  localparam logic [7:0] IDX_FLAG  = 8'h0C;
  localparam logic [7:0] IDX_VALID = 8'h0D;

  localparam logic [7:0] RATE_RST  = 8'h26;
  localparam logic [7:0] MASK_RST  = 8'h02;
  localparam logic [7:0] MASK_SET  = 8'h02;
  localparam logic [7:0] VALID_VAL = 8'h80;

  localparam int EXP_W = 5;

  // Rate field usable: divider field at most 2 and a nonzero select
  function automatic logic rate_usable(input logic [7:0] a);
    return (a[6:4] <= 3'd2) && (a[3:0] != 4'd0);
  endfunction

  // Period exponent: two special codes, otherwise offset select
  function automatic logic [EXP_W-1:0] rate_exp(input logic [7:0] a);
    if (a == 8'h21)      return 5'd12;
    else if (a == 8'h22) return 5'd13;
    else                 return 5'd4 + {1'b0, a[3:0]};
  endfunction
endpackage

// File: rtl/rtc_cmos_ram.sv
module rtc_cmos_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rtc_period_timer.sv
module rtc_period_timer #(
  parameter int CNT_W = 20,
  parameter int EXP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [EXP_W-1:0] exp_d,
  input  logic             arm_evt,
  input  logic             arm_ok,
  output logic             expire,
  output logic             armed
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_inc, mask;

  always_comb begin
    mask    = (ONE << exp_d) - ONE;
    cnt_inc = cnt_q + ONE;
    expire  = armed && tick && ((cnt_inc & mask) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      armed <= 1'b0;
    end else begin
      if (tick) cnt_q <= cnt_inc;
      if (expire)       armed <= 1'b0;
      else if (arm_evt) armed <= arm_ok;
    end
  end

  // An event lands on the period grid of the base count
  assert_grid_aligned_R7: assert property (@(posedge clk) disable iff (rst)
    expire |=> ((cnt_q & $past(mask)) == '0));

  // An event leaves the timer disarmed
  assert_disarm_after_event_R8: assert property (@(posedge clk) disable iff (rst)
    expire |=> !armed);
endmodule

// File: rtl/rtc_periodic_unit.sv
module rtc_periodic_unit
  import rtc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_rvalid,
  output logic       irq,
  output logic       wr_err
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0] idx_q, rate_q, mask_q;
  logic       flag_q;
  logic       use_mem_q;
  logic [7:0] spec_q, mem_q;

  logic in_range, is_rate, is_mask, is_flag, is_valid, special;
  logic data_wr, data_rd, idx_wr, flag_rd;
  logic [7:0] rate_nx, mask_nx, rd_spec;
  logic flag_nx, arm_evt, arm_ok, expire, tm_armed, req_now;

  always_comb begin
    in_range = int'(idx_q) < DEPTH;
    is_rate  = idx_q == IDX_RATE;
    is_mask  = idx_q == IDX_MASK;
    is_flag  = idx_q == IDX_FLAG;
    is_valid = idx_q == IDX_VALID;
    special  = is_rate || is_mask || is_flag || is_valid;
    data_wr  = bus_wr && bus_sel;
    data_rd  = bus_rd && bus_sel;
    idx_wr   = bus_wr && !bus_sel;
    flag_rd  = data_rd && is_flag;

    rate_nx  = (data_wr && is_rate) ? {1'b0, bus_wdata[6:0]} : rate_q;
    mask_nx  = (data_wr && is_mask) ? (bus_wdata | MASK_SET) : mask_q;
    flag_nx  = (flag_q && !flag_rd) || expire;
    arm_evt  = (data_wr && is_rate) || flag_rd;
    arm_ok   = rate_usable(rate_nx) && !flag_nx;
    req_now  = |({flag_q, 2'b00} & mask_q[6:4]);

    if (!bus_sel)      rd_spec = idx_q;
    else if (is_rate)  rd_spec = rate_q;
    else if (is_mask)  rd_spec = mask_q;
    else if (is_flag)  rd_spec = {req_now, flag_q, 6'b0};
    else if (is_valid) rd_spec = VALID_VAL;
    else               rd_spec = 8'h00;
  end

  rtc_period_timer #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .exp_d   (rate_exp(rate_q)),
    .arm_evt (arm_evt),
    .arm_ok  (arm_ok),
    .expire  (expire),
    .armed   (tm_armed)
  );

  rtc_cmos_ram #(.DEPTH(DEPTH), .W(8)) u_ram (
    .clk   (clk),
    .we    (data_wr && in_range && !special),
    .waddr (idx_q[AW-1:0]),
    .wdata (bus_wdata),
    .re    (data_rd),
    .raddr (idx_q[AW-1:0]),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= 8'h00;
      rate_q     <= RATE_RST;
      mask_q     <= MASK_RST;
      flag_q     <= 1'b0;
      irq        <= 1'b0;
      wr_err     <= 1'b0;
      bus_rvalid <= 1'b0;
      use_mem_q  <= 1'b0;
      spec_q     <= 8'h00;
    end else begin
      if (idx_wr) idx_q <= bus_wdata;
      rate_q     <= rate_nx;
      mask_q     <= mask_nx;
      flag_q     <= flag_nx;
      irq        <= |({flag_nx, 2'b00} & mask_nx[6:4]);
      if (data_wr && (!in_range || is_flag || is_valid)) wr_err <= 1'b1;
      bus_rvalid <= bus_rd;
      use_mem_q  <= data_rd && in_range && !special;
      spec_q     <= bus_rd ? rd_spec : 8'h00;
    end
  end

  assign bus_rdata = use_mem_q ? mem_q : spec_q;

  assert_field_rules_R4: assert property (@(posedge clk) disable iff (rst)
    !rate_q[7] && mask_q[1]);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);

  assert_no_arm_while_flagged_R8: assert property (@(posedge clk) disable iff (rst)
    flag_q |-> !tm_armed);

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag_q && mask_q[6]));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && !expire) |=> !flag_q);
endmodule

// File: tb/tb_rtc_periodic_unit.sv
module tb_rtc_periodic_unit;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic bus_rvalid, irq, wr_err;

  rtc_periodic_unit dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq), .wr_err(wr_err)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int tc;
  bit done = 0;

  always @(posedge clk) begin
    if (rst) tc <= 0;
    else if (tick) tc <= tc + 1;
  end

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  // scoreboard: expected read bytes (negative means don't care)
  int    exp_q[$];
  string tag_q[$];

  always @(negedge clk) begin : monitor
    int e;
    string t;
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2 unexpected read actual=0x%0h expected=none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e >= 0) chk(t, int'(bus_rdata), e);
      end
    end
  end

  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(bit sel, int exp, string tag);
    @(negedge clk);
    bus_sel = sel; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
    wr(1'b0, idx); wr(1'b1, d);
  endtask

  task automatic reg_rd(logic [7:0] idx, int exp, string tag);
    wr(1'b0, idx); rd(1'b1, exp, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // called at the negedge right after the arming edge
  task automatic expect_fire(int d, string tag);
    int b = 1 << d;
    int target = (tc / b + 1) * b;
    int k = 0;
    while (irq !== 1'b1 && k < b + 20) begin
      @(negedge clk);
      k++;
    end
    chk(tag, tc, target);
  endtask

  task automatic quiesce();
    reg_wr(8'h0A, 8'h20);
    reg_rd(8'h0C, -1, "R10 prep");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick = 1'b1;
    do_reset();
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 wr_err", int'(wr_err), 0);
    reg_rd(8'h0A, 8'h26, "R1 reg A");
    reg_rd(8'h0B, 8'h02, "R1 reg B");
    reg_rd(8'h0D, 8'h80, "R1 reg D");
    repeat (1100) @(negedge clk);
    reg_rd(8'h0C, 8'h00, "R1 disarmed C");
    // R2 index port
    wr(1'b0, 8'h3F);
    rd(1'b0, 8'h3F, "R2 index readback");
    // R3 storage
    reg_wr(8'h00, 8'h11);
    reg_wr(8'h05, 8'h5A);
    reg_wr(8'h3F, 8'hA5);
    reg_rd(8'h00, 8'h11, "R3 idx 00");
    reg_rd(8'h05, 8'h5A, "R3 idx 05");
    reg_rd(8'h3F, 8'hA5, "R3 idx 3F");
    // R5 out of range
    chk("R5 err before", int'(wr_err), 0);
    reg_wr(8'h40, 8'h77);
    chk("R5 err out of range", int'(wr_err), 1);
    reg_rd(8'h00, 8'h11, "R5 no alias write");
    reg_rd(8'h40, 8'h00, "R5 out of range read");
    reg_wr(8'h05, 8'h66);
    chk("R5 err sticky", int'(wr_err), 1);
    reg_rd(8'h05, 8'h66, "R3 overwrite");
    // R5 C and D writes rejected
    do_reset();
    reg_wr(8'h0C, 8'hFF);
    chk("R5 err on C write", int'(wr_err), 1);
    reg_wr(8'h0D, 8'h00);
    reg_rd(8'h0D, 8'h80, "R5 D unchanged");
    reg_rd(8'h0C, 8'h00, "R5 C unchanged");
    // R4 field rules
    reg_wr(8'h0A, 8'hA0);
    reg_rd(8'h0A, 8'h20, "R4 A bit7 dropped");
    reg_wr(8'h0B, 8'h00);
    reg_rd(8'h0B, 8'h02, "R4 B bit1 forced");
    reg_wr(8'h0B, 8'h40);
    reg_rd(8'h0B, 8'h42, "R4 B enable");
    // R6 invalid rates never arm
    reg_wr(8'h0A, 8'h31);
    repeat (200) @(negedge clk);
    chk("R6 divider field 3", int'(irq), 0);
    reg_wr(8'h0A, 8'h20);
    repeat (100) @(negedge clk);
    chk("R6 zero select", int'(irq), 0);
    // R7 alignment on A write
    reg_wr(8'h0A, 8'h24);
    expect_fire(8, "R7 d=8 grid");
    chk("R9 irq on event", int'(irq), 1);
    // R8 flag holds, A write does not rearm
    repeat (300) @(negedge clk);
    chk("R8 flag holds", int'(irq), 1);
    reg_wr(8'h0A, 8'h23);
    reg_rd(8'h0C, 8'hC0, "R10 read with request");
    chk("R10 cleared irq", int'(irq), 0);
    expect_fire(7, "R10 realign after read");
    // R7 recompute on A write while armed
    quiesce();
    while ((tc % 1024) > 800) @(negedge clk);
    reg_wr(8'h0A, 8'h26);
    repeat (10) @(negedge clk);
    reg_wr(8'h0A, 8'h23);
    expect_fire(7, "R7 recompute");
    // R6 special codes
    quiesce();
    reg_wr(8'h0A, 8'h21);
    expect_fire(12, "R6 code 21 d=12");
    quiesce();
    reg_wr(8'h0A, 8'h22);
    expect_fire(13, "R6 code 22 d=13");
    // R9 mask and R10 bit7 follows request
    quiesce();
    reg_wr(8'h0B, 8'h02);
    reg_wr(8'h0A, 8'h23);
    repeat (300) @(negedge clk);
    chk("R9 masked", int'(irq), 0);
    reg_rd(8'h0C, 8'h40, "R10 bit7 masked");
    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule